// File: doc/BRIEF.md
# Keyed-restart watchdog timer

This block is a watchdog that must be serviced by software through a small register bus (address, write strobe, write data, combinational read data). Once started, a down counter runs for a power-of-two number of clock cycles. If software does not write a fixed key value into the restart register in time, the block responds: either straight away with a system reset pulse, or first with an interrupt and then, if the interrupt is still not serviced by the next expiry, with the reset pulse.

The period is chosen by a 4-bit exponent `i`, which gives `2^(EXP_BASE+i)` cycles. `EXP_BASE` defaults to 16, so the counter is 32 bits wide. One exponent field applies to the first count after start-up and a second field applies to every later reload. Once the watchdog is running, only the block reset stops it.

Top module: `kwdt_top`

## Requirements
- R1: After reset, the control register (offset 0x00) and the timeout register (offset 0x04) read zero, and both `wdt_irq` and `wdt_sys_rst` are low.
- R2: Offset 0x00 reads back {mode at bit 1, enable at bit 0}. Offset 0x04 reads back the 8 bits last written: normal exponent in bits [3:0], start-up exponent in bits [7:4]. Offset 0x0C and every other unused offset read zero.
- R3: Once enable is set, writing 0 to bit 0 does not stop the watchdog. While the watchdog runs, the mode bit (bit 1) keeps its value.
- R4: Writing 1 to bit 0 while the watchdog is stopped starts it. The first expiry follows `2^(EXP_BASE+tmo[7:4])` clock edges after the edge that wrote the enable.
- R5: Writing exactly 0x00000076 to offset 0x0C while the watchdog runs reloads the counter. The next expiry then follows `2^(EXP_BASE+tmo[3:0])` edges after that write.
- R6: A write to offset 0x0C with any other value does not reload the counter and does not clear the interrupt.
- R7: In mode 0, each expiry starts a system reset pulse and reloads the counter with the normal period.
- R8: In mode 1, an expiry while no interrupt is pending raises `wdt_irq` without a reset and reloads the counter with the normal period. An expiry while the interrupt is pending starts a system reset pulse.
- R9: A valid key write drops `wdt_irq` at the edge of the write.
- R10: `wdt_sys_rst` stays high for exactly `RST_CYCLES` (default 8) cycles per expiry that triggers it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wdt_irq | output | 1 | Pending early-warning interrupt (mode 1) |
| wdt_sys_rst | output | 1 | System reset pulse |

## Verification
The assertions assume that a key write never lands in the same cycle as an expiry. They also assume that the reset pulse finishes before the next expiry, which holds as long as `RST_CYCLES` is shorter than the smallest period. The stimulus places every restart write well away from the computed expiry edges. It uses short periods (a small `EXP_BASE`) so that two expiries fit in a short run. It applies the block reset between scenarios, because a running watchdog cannot be stopped in any other way.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int EXP_W      = 4;
  localparam int EXP_LEVELS = 1 << EXP_W;
  localparam int OFS_CTRL   = 'h0;
  localparam int OFS_TMO    = 'h4;
  localparam int OFS_KICK   = 'hC;
  localparam logic [31:0] KICK_KEY = 32'h0000_0076;

  typedef struct packed {
    logic [EXP_W-1:0] first;
    logic [EXP_W-1:0] normal;
  } tmo_t;
endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              en,
  output logic              irq_mode,
  output tmo_t              tmo,
  output logic              start,
  output logic              kick
);
  logic en_q, en_d, mode_q, mode_d;
  tmo_t tmo_q, tmo_d;
  logic sel_ctrl, sel_tmo, sel_kick;

  assign sel_ctrl = (addr == ADDR_W'(OFS_CTRL));
  assign sel_tmo  = (addr == ADDR_W'(OFS_TMO));
  assign sel_kick = (addr == ADDR_W'(OFS_KICK));

  always_comb begin
    en_d   = en_q;
    mode_d = mode_q;
    tmo_d  = tmo_q;
    start  = 1'b0;
    kick   = 1'b0;
    if (wr_en && sel_ctrl && !en_q) begin
      mode_d = wr_data[1];
      if (wr_data[0]) begin
        en_d  = 1'b1;
        start = 1'b1;
      end
    end
    if (wr_en && sel_tmo) tmo_d = tmo_t'(wr_data[7:0]);
    if (wr_en && sel_kick && en_q && (wr_data == DATA_W'(KICK_KEY))) kick = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      tmo_q  <= '0;
    end else begin
      en_q   <= en_d;
      mode_q <= mode_d;
      tmo_q  <= tmo_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (sel_ctrl)     rd_data = DATA_W'({mode_q, en_q});
    else if (sel_tmo) rd_data = DATA_W'(tmo_q);
  end

  assign en       = en_q;
  assign irq_mode = mode_q;
  assign tmo      = tmo_q;

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q); // R3
  AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable(mode_q)); // R3
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
  import kwdt_pkg::*;
#(
  parameter int EXP_BASE = 16,
  parameter int CNT_W    = EXP_BASE + EXP_LEVELS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start,
  input  logic kick,
  input  tmo_t tmo,
  output logic expire
);
  logic [CNT_W-1:0] per_tab [EXP_LEVELS];
  logic [CNT_W-1:0] cnt_q, cnt_d;

  for (genvar g = 0; g < EXP_LEVELS; g++) begin : g_per
    assign per_tab[g] = CNT_W'((64'd1 << (EXP_BASE + g)) - 64'd1);
  end

  assign expire = en && (cnt_q == '0) && !kick;

  always_comb begin
    cnt_d = cnt_q;
    if (start)                 cnt_d = per_tab[tmo.first];
    else if (kick || expire)   cnt_d = per_tab[tmo.normal];
    else if (en && cnt_q != 0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == per_tab[$past(tmo.first)])); // R4
  AST_KICK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt_q == per_tab[$past(tmo.normal)])); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (cnt_q == '0)); // R1
endmodule

// File: rtl/kwdt_resp.sv
module kwdt_resp #(
  parameter int RST_CYCLES = 8,
  parameter int PW_W       = $clog2(RST_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_mode,
  input  logic expire,
  input  logic kick,
  output logic irq,
  output logic sys_rst
);
  logic            irq_q, irq_d, fire;
  logic [PW_W-1:0] pw_q, pw_d;

  assign fire = expire && (!irq_mode || irq_q);

  always_comb begin
    irq_d = irq_q;
    if (kick)                       irq_d = 1'b0;
    else if (expire && irq_mode)    irq_d = 1'b1;
    pw_d = pw_q;
    if (fire)           pw_d = PW_W'(RST_CYCLES);
    else if (pw_q != 0) pw_d = pw_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      pw_q  <= '0;
    end else begin
      irq_q <= irq_d;
      pw_q  <= pw_d;
    end
  end

  assign irq     = irq_q;
  assign sys_rst = (pw_q != 0);

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !irq_q); // R9
  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> $past(expire)); // R7
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(expire && irq_mode)); // R8
  AST_WARN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && irq_mode && !irq_q && pw_q == 0) |=> !sys_rst); // R8
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int EXP_BASE   = 16,
  parameter int RST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wdt_irq,
  output logic              wdt_sys_rst
);
  localparam int CNT_W = EXP_BASE + EXP_LEVELS;

  logic en, irq_mode, start, kick, expire;
  tmo_t tmo;

  kwdt_regs #(.ADDR_W(ADDR_W), .DATA_W(32)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr_en(bus_wr),
    .wr_data(bus_wdata), .rd_data(bus_rdata), .en(en), .irq_mode(irq_mode),
    .tmo(tmo), .start(start), .kick(kick)
  );

  kwdt_counter #(.EXP_BASE(EXP_BASE), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start), .kick(kick),
    .tmo(tmo), .expire(expire)
  );

  kwdt_resp #(.RST_CYCLES(RST_CYCLES)) u_resp (
    .clk(clk), .rst_n(rst_n), .irq_mode(irq_mode), .expire(expire),
    .kick(kick), .irq(wdt_irq), .sys_rst(wdt_sys_rst)
  );
endmodule

// File: tb/sim_kwdt_top.sv
`timescale 1ns/1ps
module sim_kwdt_top;
  localparam int EXP_BASE = 4;
  localparam int RSTC     = 8;
  localparam int K_IRQ_UP = 0, K_IRQ_DN = 1, K_RST_UP = 2, K_RST_DN = 3;

  typedef struct { int kind; int cyc; string req; } ev_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, srst;
  logic        p_irq = 1'b0, p_srst = 1'b0;
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  ev_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  kwdt_top #(.ADDR_W(4), .EXP_BASE(EXP_BASE), .RST_CYCLES(RSTC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rdata(rdata), .wdt_irq(irq), .wdt_sys_rst(srst)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_ev(input int kind, input int c, input string req);
    ev_t e;
    e.kind = kind; e.cyc = c; e.req = req;
    q.push_back(e);
  endtask

  task automatic got_ev(input int kind);
    ev_t e;
    if (q.size() == 0) begin
      chk(1'b0, "R7/R8", "unexpected output edge kind", kind, -1);
    end else begin
      e = q.pop_front();
      chk(e.kind == kind, e.req, "output edge kind", kind, e.kind);
      chk(e.cyc == cyc, e.req, "output edge cycle", cyc, e.cyc);
    end
  endtask

  // monitor: compares output edges against the scoreboard queue
  always @(negedge clk) begin
    if (!rst_n) begin
      p_irq = irq; p_srst = srst;
    end else begin
      if (irq && !p_irq)   got_ev(K_IRQ_UP);
      if (!irq && p_irq)   got_ev(K_IRQ_DN);
      if (srst && !p_srst) got_ev(K_RST_UP);
      if (!srst && p_srst) got_ev(K_RST_DN);
      p_irq = irq; p_srst = srst;
    end
  end

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d, output int e);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk);
    #1;
    e = cyc;
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, input int exp, input string req);
    @(negedge clk);
    addr = a;
    #1;
    chk(rdata == 32'(exp), req, $sformatf("read offset 0x%0h", a), int'(rdata), exp);
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int k, r, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1;
    chk(irq == 1'b0, "R1", "irq after reset", int'(irq), 0);
    chk(srst == 1'b0, "R1", "sys_rst after reset", int'(srst), 0);
    bus_read(4'h0, 0, "R1");
    bus_read(4'h4, 0, "R1");
    // R2 map
    bus_write(4'h4, 32'h0000_0021, e);
    bus_read(4'h4, 'h21, "R2");
    bus_read(4'h8, 0, "R2");
    bus_read(4'hC, 0, "R2");

    // Mode 0: first period 2^(4+2)=64, normal 2^(4+1)=32
    bus_write(4'h0, 32'h1, k);
    expect_ev(K_RST_UP, k + 64, "R4");
    expect_ev(K_RST_DN, k + 64 + RSTC, "R10");
    bus_read(4'h0, 1, "R2");
    bus_write(4'h0, 32'h0, e);
    bus_read(4'h0, 1, "R3");
    bus_write(4'hC, 32'h75, e);          // R6 wrong key
    bus_write(4'hC, 32'h0000_0176, e);   // R6 wrong upper bits
    wait_cyc(k + 80);
    bus_write(4'hC, 32'h76, r);
    expect_ev(K_RST_UP, r + 32, "R5");
    expect_ev(K_RST_DN, r + 32 + RSTC, "R7");
    wait_cyc(r + 48);
    chk(q.size() == 0, "R7", "pending events after mode 0", q.size(), 0);
    do_reset();
    bus_read(4'h0, 0, "R1");
    chk(q.size() == 0, "R1", "no output edge across reset", q.size(), 0);

    // Mode 1
    bus_write(4'h4, 32'h0000_0021, e);
    bus_write(4'h0, 32'h3, k);
    expect_ev(K_IRQ_UP, k + 64, "R8");
    bus_write(4'h0, 32'h1, e);
    bus_read(4'h0, 3, "R3");
    wait_cyc(k + 66);
    bus_write(4'hC, 32'h12, e);          // R6 wrong key leaves irq set
    #1;
    chk(irq == 1'b1, "R6", "irq after wrong key", int'(irq), 1);
    bus_write(4'hC, 32'h76, r);
    expect_ev(K_IRQ_DN, r, "R9");
    expect_ev(K_IRQ_UP, r + 32, "R8");
    expect_ev(K_RST_UP, r + 64, "R8");
    expect_ev(K_RST_DN, r + 64 + RSTC, "R10");
    wait_cyc(r + 80);
    chk(q.size() == 0, "R8", "pending events after mode 1", q.size(), 0);
    chk(irq == 1'b1, "R8", "irq stays pending", int'(irq), 1);
    do_reset();
    #1;
    chk(irq == 1'b0, "R1", "irq cleared by reset", int'(irq), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule